// File: doc/BRIEF.md
# Watchdog Timer with Programmable Postscaler

This block is a watchdog timer that runs on its own low-frequency clock. A fixed prescaler divides that clock down to a base tick. A power-of-two postscaler, whose tap is chosen by a 4-bit configuration field, then stretches the tick into the full timeout. If nothing restarts the counters before the selected count is reached, the block emits a one-cycle timeout pulse. That pulse goes out on the reset-request output while the device is awake, and on the wake-up output while it is asleep.

Several events restart both counters: an explicit clear command, entry into sleep, an indication that a system oscillator has failed, and any device reset. The watchdog runs when either the hardware configuration enable or the software enable bit is set. The software bit sits in bit 0 of a byte-wide control register. While the watchdog runs, the block also asserts a clock-enable request for its oscillator.

Top module: `wdog_postscale`

## Requirements
- R1: While reset is asserted and right after it is released, both timeout outputs are low, the control register reads 0x00, and the clock-enable output follows only the hardware enable.
- R2: A register write stores write-data bit 0 as the software enable. The register reads back that bit in bit 0, and bits 7 to 1 always read 0.
- R3: The watchdog is enabled when the hardware enable is 1 or the software enable bit is 1. The clock-enable output equals that enable at all times.
- R4: While the watchdog is disabled, no timeout is produced and the counters are held at zero. After enabling, a full timeout period is counted from zero.
- R5: With select value s, a timeout occurs PRE_DIV × 2^s clock cycles after the counters restart. Value 0 gives ratio 1:1, and each increment doubles the ratio.
- R6: A timeout output is high for exactly one cycle. The counters restart at that cycle, so timeouts repeat every PRE_DIV × 2^s cycles while the watchdog runs undisturbed.
- R7: A clear command restarts both counters, and no timeout output follows in the next cycle.
- R8: A sleep-entry strobe restarts both counters.
- R9: A clock-failure indication restarts both counters.
- R10: On timeout, wakeReq pulses if asleep is 1 and resetReq pulses if asleep is 0. The two are never high together.
- R11: When the hardware enable is 1, the watchdog runs even if the software enable bit is 0.
- R12: A device reset clears the counters, so a full period is counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rstN | input | 1 | Device reset, asynchronous, active low |
| hwEnable | input | 1 | Hardware configuration enable; overrides the software bit |
| postSel | input | 4 | Postscaler tap select, ratio 2^postSel |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data; bit 0 is the software enable |
| regRdData | output | 8 | Control register read data |
| clearCmd | input | 1 | Clear-watchdog command strobe |
| sleepCmd | input | 1 | Sleep-entry strobe |
| asleep | input | 1 | Device is in the power-managed sleep state |
| clkFail | input | 1 | Primary or secondary oscillator failure indication |
| wdtClkEn | output | 1 | Request to keep the watchdog oscillator running |
| resetReq | output | 1 | One-cycle device reset request on timeout while awake |
| wakeReq | output | 1 | One-cycle wake-up request on timeout while asleep |

## Verification
On every cycle, the assertions check these properties: timeout pulses last one cycle, the two timeout outputs are mutually exclusive, and the output chosen matches the sleep state. They also check that the clock-enable output tracks the combined enable, that the unused register bits read zero, and that no timeout follows a cycle that is disabled or cleared. Other behaviour is visible only in the bench's scenarios, because it depends on counting long intervals. That covers the exact timeout length for each postscaler tap, the doubling from tap to tap, and the repeat period. It also covers the fact that each restart source (clear, sleep, clock failure, reset, enabling) starts a full period from zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic run;    // count this cycle
    logic clear;  // force both counters to zero
  } wdStrobe_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int PRE_DIV = 128,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [SEL_W-1:0] postSel,
  output logic             expire
);
  localparam int PRE_W  = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int TAPS   = 1 << SEL_W;
  localparam int POST_W = TAPS - 1;

  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic [POST_W-1:0] tapMask [TAPS];
  logic              preTick;
  logic              postHit;

  // Terminal count of the postscaler for each tap
  for (genvar g = 0; g < TAPS; g++) begin : gTap
    assign tapMask[g] = POST_W'((64'd1 << g) - 64'd1);
  end

  assign preTick = (preCnt == PRE_W'(PRE_DIV - 1));
  // >= keeps a shrinking select from waiting for a full wrap
  assign postHit = (postCnt >= tapMask[postSel]);
  assign expire  = strobe.run & preTick & postHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (strobe.clear || expire) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (strobe.run) begin
      if (preTick) begin
        preCnt  <= '0;
        postCnt <= postCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwEnable,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       clearCmd,
  input  logic       sleepCmd,
  input  logic       clkFail,
  input  logic       asleep,
  input  logic       expire,
  output wdStrobe_t  strobe,
  output logic [7:0] regRdData,
  output logic       wdtClkEn,
  output logic       resetReq,
  output logic       wakeReq
);
  logic [7:0] ctrlReg;
  logic       enable;
  logic       restart;

  // Only bit 0 is implemented; the rest is stored as zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlReg <= 8'h00;
    else if (regWrEn) ctrlReg <= regWrData & 8'h01;
  end

  assign regRdData = ctrlReg;
  assign enable    = hwEnable | ctrlReg[0];
  assign wdtClkEn  = enable;
  assign restart   = clearCmd | sleepCmd | clkFail | ~enable;

  always_comb begin
    strobe.run   = enable & ~restart;
    strobe.clear = restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
    end else begin
      resetReq <= expire & ~asleep;
      wakeReq  <= expire & asleep;
    end
  end
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale
  import wdog_pkg::*;
#(
  parameter int PRE_DIV = 128,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwEnable,
  input  logic [SEL_W-1:0] postSel,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             clearCmd,
  input  logic             sleepCmd,
  input  logic             asleep,
  input  logic             clkFail,
  output logic             wdtClkEn,
  output logic             resetReq,
  output logic             wakeReq
);
  wdStrobe_t strobe;
  logic      expire;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .clearCmd(clearCmd), .sleepCmd(sleepCmd), .clkFail(clkFail),
    .asleep(asleep), .expire(expire), .strobe(strobe),
    .regRdData(regRdData), .wdtClkEn(wdtClkEn),
    .resetReq(resetReq), .wakeReq(wakeReq)
  );

  wdog_count #(.PRE_DIV(PRE_DIV), .SEL_W(SEL_W)) u_count (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .postSel(postSel), .expire(expire)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hwEnable,
  input logic       clearCmd,
  input logic       asleep,
  input logic [7:0] regRdData,
  input logic       wdtClkEn,
  input logic       resetReq,
  input logic       wakeReq
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || wakeReq) |=> !(resetReq || wakeReq)); // R6
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && wakeReq)); // R10
  AST_WAKE_WHEN_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(asleep)); // R10
  AST_RESET_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(asleep)); // R10
  AST_CLKEN_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    wdtClkEn == (hwEnable | regRdData[0])); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:1] == 7'd0); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wdtClkEn |=> !(resetReq || wakeReq)); // R4
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> !(resetReq || wakeReq)); // R7
endmodule

bind wdog_postscale wdog_checker u_chk (
  .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .clearCmd(clearCmd),
  .asleep(asleep), .regRdData(regRdData), .wdtClkEn(wdtClkEn),
  .resetReq(resetReq), .wakeReq(wakeReq)
);

// File: tb/wdog_postscale_test.sv
module wdog_postscale_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_DIV    = 4;
  localparam int MAX_SWEEP  = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hwEnable = 1'b0;
  logic [3:0] postSel = 4'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       clearCmd = 1'b0, sleepCmd = 1'b0, asleep = 1'b0, clkFail = 1'b0;
  logic       wdtClkEn, resetReq, wakeReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_postscale #(.PRE_DIV(PRE_DIV), .SEL_W(4)) uut (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .postSel(postSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .clearCmd(clearCmd), .sleepCmd(sleepCmd), .asleep(asleep),
    .clkFail(clkFail), .wdtClkEn(wdtClkEn), .resetReq(resetReq),
    .wakeReq(wakeReq)
  );

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Called at a negedge; counts posedges until a timeout output is seen
  task automatic waitPulse(input int limit, output int cnt, output bit gotWake,
                           output bit gotReset);
    cnt = 0; gotWake = 0; gotReset = 0;
    while (cnt <= limit) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (resetReq || wakeReq) begin
        gotWake = wakeReq; gotReset = resetReq;
        break;
      end
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseClear();
    clearCmd = 1'b1; @(posedge clk); @(negedge clk); clearCmd = 1'b0;
  endtask

  int n, cnt;
  bit gw, gr;

  initial begin
    @(negedge clk);
    // R1: state under reset
    check("R1 resetReq", resetReq, 0);
    check("R1 wakeReq", wakeReq, 0);
    check("R1 regRd", regRdData, 0);
    check("R1 clkEn", wdtClkEn, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 regRd after release", regRdData, 0);

    // R2: register bit 0 only
    writeReg(8'hFF);
    check("R2 readback FF", regRdData, 1);
    writeReg(8'hFE);
    check("R2 readback FE", regRdData, 0);
    check("R3 clkEn off", wdtClkEn, 0);

    // R4: disabled, nothing happens
    postSel = 4'd0;
    waitPulse(40, cnt, gw, gr);
    check("R4 no pulse disabled", int'(gw | gr), 0);

    // R4/R3: enabling starts a full period from zero
    postSel = 4'd2; n = PRE_DIV * 4;
    writeReg(8'h01);
    check("R3 clkEn sw", wdtClkEn, 1);
    waitPulse(n + 8, cnt, gw, gr);
    check("R4 period after enable", cnt, n);

    // R5/R6: sweep taps
    for (int s = 0; s <= MAX_SWEEP; s++) begin
      postSel = 4'(s); n = PRE_DIV * (1 << s);
      pulseClear();
      waitPulse(n + 8, cnt, gw, gr);
      check($sformatf("R5 first period sel %0d", s), cnt, n);
      check("R10 awake gives reset", int'(gr), 1);
      @(posedge clk); @(negedge clk);
      check("R6 pulse one cycle", int'(resetReq | wakeReq), 0);
      waitPulse(n + 8, cnt, gw, gr);
      check($sformatf("R6 repeat period sel %0d", s), cnt, n - 1);
    end

    // R7: clear mid-count restarts
    postSel = 4'd3; n = PRE_DIV * 8;
    pulseClear();
    repeat (n - 3) @(negedge clk);
    pulseClear();
    waitPulse(n + 8, cnt, gw, gr);
    check("R7 clear restarts", cnt, n);

    // R9: clock failure mid-count restarts
    pulseClear();
    repeat (n / 2) @(negedge clk);
    clkFail = 1'b1; @(posedge clk); @(negedge clk); clkFail = 1'b0;
    waitPulse(n + 8, cnt, gw, gr);
    check("R9 clkFail restarts", cnt, n);

    // R8/R10: sleep entry restarts, timeout wakes
    pulseClear();
    repeat (n / 2) @(negedge clk);
    asleep = 1'b1;
    sleepCmd = 1'b1; @(posedge clk); @(negedge clk); sleepCmd = 1'b0;
    waitPulse(n + 8, cnt, gw, gr);
    check("R8 sleep restarts", cnt, n);
    check("R10 asleep gives wake", int'(gw), 1);
    check("R10 asleep no reset", int'(gr), 0);
    asleep = 1'b0;

    // R11: hardware enable overrides software 0
    writeReg(8'h00);
    hwEnable = 1'b1;
    @(negedge clk);
    check("R11 clkEn hw", wdtClkEn, 1);
    check("R11 sw bit still 0", regRdData, 0);
    pulseClear();
    waitPulse(n + 8, cnt, gw, gr);
    check("R11 hw runs", cnt, n);

    // R12: device reset mid-count
    pulseClear();
    repeat (n / 2) @(negedge clk);
    rstN = 1'b0; @(negedge clk);
    check("R12 outputs low in reset", int'(resetReq | wakeReq), 0);
    rstN = 1'b1;
    waitPulse(n + 8, cnt, gw, gr);
    check("R12 full period after reset", cnt, n);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule